// File: doc/BRIEF.md
# GPIO Edge-Interrupt Pin Controller

This block manages a small bank of general-purpose pins. Each pin has an 8-bit configuration register. Through it, software can make the pin an output, switch it to open-drain drive, turn on a pull-up, store an input-threshold choice, pick the interrupt polarity and gate the interrupt. A port data register holds the level that each pin drives.

Each pad input passes through a synchroniser. The block then watches it for the selected edge and latches a pending flag for that pin. Each pin drives its own interrupt line, so the interrupt controller can give every pin a separate vector. Software clears a pending flag by writing 1 to the pin's bit in the pending register.

Detection always looks at the pad level, even when the pin is an output. Firmware can therefore raise an interrupt by writing the data register. Flipping the polarity bit while the pad is steady can look like an edge. For that reason the safe order for reconfiguring a pin is: disable, configure, clear pending, enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register, the data register (address 0x00) and the pending register (address 0x10) read 0. All irq outputs are 0 and all pad_oe outputs are 0.
- R2: In each configuration byte, bit 6 is interrupt enable, bit 5 is active-low polarity, bit 4 is threshold select, bit 2 is open drain, bit 1 is pull-up enable and bit 0 is output enable. Bits 7 and 3 always read 0, so writing 0xFF reads back 0x77. Bit 4 drives pad_ttl and bit 1 drives pad_pu.
- R3: With polarity bit 5 clear, a 0-to-1 change of pad_in sets the pin's pending flag, and irq rises on the third rising clock edge after the change (two synchroniser flops, then the flag). A 1-to-0 change sets nothing.
- R4: With polarity bit 5 set, a 1-to-0 change of pad_in sets the pending flag, and a 0-to-1 change sets nothing.
- R5: A pending flag sets whatever the value of interrupt enable. irq for a pin is high exactly when its pending flag is set and its interrupt enable is 1. Clearing the enable lowers irq and leaves the flag set.
- R6: With output enable 1 and open drain 0, pad_oe is 1 and pad_out follows the pin's data bit. With output enable 0, pad_oe is 0.
- R7: With output enable 1 and open drain 1, pad_oe is 1 only while the data bit is 0, and pad_out is 0.
- R8: When a pin is an output with interrupt enable set, writing the data register so that the pad makes the selected edge raises that pin's irq.
- R9: Writing 1 to bit i of the pending register (0x10) clears pin i's flag. Writing 0 leaves it unchanged. A clear and a new edge in the same cycle leave the flag set.
- R10: Changing bit 5 while the pad is static can set the pending flag. The sequence disable, change polarity, clear, enable leaves irq and the flag at 0.
- R11: Pin i's configuration register sits at address 0x08+i. A write to one pin's register, or an edge on one pin, has no effect on another pin's register, flag or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad driver enables |
| pad_pu | output | NPINS | Pad pull-up enables |
| pad_ttl | output | NPINS | Stored threshold-select bits |
| irq | output | NPINS | Per-pin interrupt lines |

## Verification
The bench models each pad so that a driven pin feeds its own output back, and an undriven pin reads the pull-up or an external level. This lets a data-register write trigger the pin's own interrupt. If detection were gated by output enable, that self-interrupt would never arrive.

A polarity flip on a steady pad is checked twice. Done directly, it must raise irq. Done through the safe sequence, it must leave the flag clear. A design that cleared the flag before the edge had settled would fail the second check.

The irq is sampled one edge early and then on time, so a missing or an extra synchroniser stage shows up. Open-drain drive is checked for both data values, since a design that left pad_oe high while the data bit is 1 would fight the line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W      = 8;
    localparam int BIT_IE     = 6;
    localparam int BIT_ACTLOW = 5;
    localparam int BIT_TTL    = 4;
    localparam int BIT_OD     = 2;
    localparam int BIT_PU     = 1;
    localparam int BIT_OE     = 0;

    typedef struct packed {
        logic ie;
        logic act_low;
        logic ttl;
        logic od;
        logic pu;
        logic oe;
    } pin_cfg_t;

    function automatic logic [CFG_W-1:0] cfg_to_byte(pin_cfg_t c);
        logic [CFG_W-1:0] b;
        b = '0;
        b[BIT_IE]     = c.ie;
        b[BIT_ACTLOW] = c.act_low;
        b[BIT_TTL]    = c.ttl;
        b[BIT_OD]     = c.od;
        b[BIT_PU]     = c.pu;
        b[BIT_OE]     = c.oe;
        return b;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_w,
    input  logic     data_we,
    input  logic     data_w,
    input  logic     clr_we,
    input  logic     pad_lvl,
    output pin_cfg_t cfg,
    output logic     data,
    output logic     pend,
    output logic     irq
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     data;
        logic     prev;
        logic     pend;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic       lvl_x;
    logic       hit;

    always_comb begin
        st_d  = st_q;
        lvl_x = pad_lvl ^ st_q.cfg.act_low;
        hit   = lvl_x & ~st_q.prev;
        if (cfg_we)  st_d.cfg  = cfg_w;
        if (data_we) st_d.data = data_w;
        st_d.prev = lvl_x;
        if (clr_we)  st_d.pend = 1'b0;
        if (hit)     st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign data = st_q.data;
    assign pend = st_q.pend;
    assign irq  = st_q.pend & st_q.cfg.ie;

    // R3
    pend_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(lvl_x) && !$past(st_q.prev));

    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !hit) |=> !st_q.pend);

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && cfg.ie));
endmodule

// File: rtl/gpio_irq_drive.sv
module gpio_irq_drive
    import gpio_irq_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     data,
    output logic     pad_oe,
    output logic     pad_out,
    output logic     pad_pu,
    output logic     pad_ttl
);
    always_comb begin
        pad_oe  = cfg.oe & (~cfg.od | ~data);
        pad_out = data & ~cfg.od;
        pad_pu  = cfg.pu;
        pad_ttl = cfg.ttl;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int          NPINS       = 2,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CFG_BASE    = 8'h08,
    parameter logic [7:0]  DATA_ADDR   = 8'h00,
    parameter logic [7:0]  PEND_ADDR   = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_raddr,
    output logic [7:0]       bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_ttl,
    output logic [NPINS-1:0] irq
);
    localparam int DW = 8;

    pin_cfg_t             cfg_w;
    pin_cfg_t             cfg_r [NPINS];
    logic     [NPINS-1:0] data_r, pend_r, lvl_s;
    logic                 data_sel, pend_sel;
    logic                 wdata_unused;

    initial begin
        if (NPINS < 1 || NPINS > DW) $error("NPINS out of range");
        if (SYNC_STAGES < 2)         $error("SYNC_STAGES below 2");
    end

    always_comb begin
        cfg_w.ie      = bus_wdata[BIT_IE];
        cfg_w.act_low = bus_wdata[BIT_ACTLOW];
        cfg_w.ttl     = bus_wdata[BIT_TTL];
        cfg_w.od      = bus_wdata[BIT_OD];
        cfg_w.pu      = bus_wdata[BIT_PU];
        cfg_w.oe      = bus_wdata[BIT_OE];
        data_sel      = bus_we && (bus_addr == DATA_ADDR);
        pend_sel      = bus_we && (bus_addr == PEND_ADDR);
    end

    assign wdata_unused = ^{bus_wdata[7], bus_wdata[3]};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic cfg_sel;
        assign cfg_sel = bus_we && (bus_addr == CFG_BASE + 8'(i));

        gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pad_in[i]),
            .q     (lvl_s[i])
        );

        gpio_irq_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_sel),
            .cfg_w   (cfg_w),
            .data_we (data_sel),
            .data_w  (bus_wdata[i]),
            .clr_we  (pend_sel && bus_wdata[i]),
            .pad_lvl (lvl_s[i]),
            .cfg     (cfg_r[i]),
            .data    (data_r[i]),
            .pend    (pend_r[i]),
            .irq     (irq[i])
        );

        gpio_irq_drive u_drv (
            .cfg     (cfg_r[i]),
            .data    (data_r[i]),
            .pad_oe  (pad_oe[i]),
            .pad_out (pad_out[i]),
            .pad_pu  (pad_pu[i]),
            .pad_ttl (pad_ttl[i])
        );

        // R7
        od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_r[i].od && data_r[i]) |-> !pad_oe[i]);

        // R6
        pp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_r[i].oe && !cfg_r[i].od) |-> (pad_oe[i] && pad_out[i] == data_r[i]));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_raddr == DATA_ADDR) bus_rdata[NPINS-1:0] = data_r;
        if (bus_raddr == PEND_ADDR) bus_rdata[NPINS-1:0] = pend_r;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_raddr == CFG_BASE + 8'(i)) bus_rdata = cfg_to_byte(cfg_r[i]);
        end
    end
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;

    logic          clk = 0, rst_n = 0;
    logic          bus_we = 0;
    logic [7:0]    bus_addr = 0, bus_wdata = 0, bus_raddr = 0, bus_rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_ttl, irq;
    logic [NP-1:0] ext_en = 0, ext_val = 0;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < NP; i++) begin : g_pad
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);
    end

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_ttl(pad_ttl), .irq(irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_raddr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h08, v); check("R1 cfg0", v, 8'h00);
        rd(8'h09, v); check("R1 cfg1", v, 8'h00);
        rd(8'h00, v); check("R1 data", v, 8'h00);
        rd(8'h10, v); check("R1 pend", v, 8'h00);
        check("R1 irq", 8'(irq), 8'h00);
        check("R1 oe", 8'(pad_oe), 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        wr(8'h08, 8'hFF);
        rd(8'h08, v); check("R2 readback", v, 8'h77);
        check("R2 ttl", 8'(pad_ttl), 8'h01);
        check("R2 pu", 8'(pad_pu), 8'h01);
        rd(8'h09, v); check("R11 cfg1 untouched", v, 8'h00);
        wr(8'h08, 8'h00); cyc(4); wr(8'h10, 8'h03);
    endtask

    task automatic t_drive();
        wr(8'h08, 8'h01); wr(8'h00, 8'h01);
        check("R6 oe", 8'(pad_oe[0]), 8'h01);
        check("R6 out1", 8'(pad_out[0]), 8'h01);
        wr(8'h00, 8'h00);
        check("R6 out0", 8'(pad_out[0]), 8'h00);
        wr(8'h08, 8'h05);
        check("R7 oe data0", 8'(pad_oe[0]), 8'h01);
        check("R7 out", 8'(pad_out[0]), 8'h00);
        wr(8'h00, 8'h01);
        check("R7 oe data1", 8'(pad_oe[0]), 8'h00);
        wr(8'h00, 8'h00); wr(8'h08, 8'h00);
        check("R6 oe off", 8'(pad_oe[0]), 8'h00);
        cyc(4); wr(8'h10, 8'h03);
    endtask

    task automatic t_rise();
        logic [7:0] v;
        ext_en[1] = 1; ext_val[1] = 0;
        wr(8'h09, 8'h40); cyc(4); wr(8'h10, 8'h02);
        ext_val[1] = 1;
        cyc(2); check("R3 not early", 8'(irq), 8'h00);
        cyc(1); check("R3 rise irq", 8'(irq), 8'h02);
        rd(8'h10, v); check("R11 pend only pin1", v, 8'h02);
        wr(8'h10, 8'h02);
        ext_val[1] = 0; cyc(4);
        rd(8'h10, v); check("R3 fall ignored", v, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        wr(8'h09, 8'h20); cyc(4); wr(8'h10, 8'h02); wr(8'h09, 8'h60);
        ext_val[1] = 1; cyc(4);
        rd(8'h10, v); check("R4 rise ignored", v, 8'h00);
        ext_val[1] = 0; cyc(4);
        check("R4 fall irq", 8'(irq), 8'h02);
        wr(8'h10, 8'h00);
        rd(8'h10, v); check("R9 zero no clear", v, 8'h02);
        wr(8'h09, 8'h20);
        check("R5 irq off", 8'(irq), 8'h00);
        rd(8'h10, v); check("R5 pend kept", v, 8'h02);
        wr(8'h10, 8'h02);
        rd(8'h10, v); check("R9 clear", v, 8'h00);
    endtask

    task automatic t_toggle();
        logic [7:0] v;
        wr(8'h09, 8'h40); cyc(4); wr(8'h10, 8'h02);
        wr(8'h09, 8'h60); cyc(2);
        check("R10 spurious", 8'(irq), 8'h02);
        wr(8'h09, 8'h00); cyc(3); wr(8'h10, 8'h02);
        wr(8'h09, 8'h20); cyc(2);
        check("R10 masked", 8'(irq), 8'h00);
        wr(8'h10, 8'h02); wr(8'h09, 8'h60); cyc(4);
        check("R10 safe irq", 8'(irq), 8'h00);
        rd(8'h10, v); check("R10 safe pend", v, 8'h00);
    endtask

    task automatic t_self();
        wr(8'h08, 8'h41); cyc(4); wr(8'h10, 8'h01);
        wr(8'h00, 8'h01); cyc(4);
        check("R8 self irq", 8'(irq[0]), 8'h01);
        check("R11 pin1 quiet", 8'(irq[1]), 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset(); t_layout(); t_drive(); t_rise();
        t_fall(); t_toggle(); t_self();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule